// File: doc/BRIEF.md
# Single-Pass Channel Conversion Sequencer

This block schedules conversions for a converter core that has several input channels. A sequence starts from the powered-down state when the single-conversion mode code is written. The block then waits a fixed number of cycles for the oscillator to start. After that it converts every channel set in a sampled enable mask, one channel at a time from the lowest index up. Each result goes into a held output register, together with a channel tag that the serial interface reports in the low four bits of its status word. When the last enabled channel has produced its result, the block powers itself down.

The converter core is a behavioural model: a counter that runs for a fixed number of cycles and then returns a test word. Each new conversion starts on the same edge that publishes the previous result. The result register is overwritten by every later conversion, so a reader has only one conversion time to fetch a result. The result port uses a valid/ready pair with no back-pressure. `res_valid` is the ready flag. A reader asserts `res_ready` to mark the word as read, and this clears the flag. The data and tag stay readable after that. Holding `res_ready` low never stalls the sequence: a new result replaces the old one and sets the flag again.

Top module: `conv_seq_top`

## Requirements
- R1: After reset, `pwr_down`=1, `conv_busy`=0, `res_valid`=0, `res_data`=0 and `res_chan`=0.
- R2: A sequence starts only when `mode_wr` is high with `mode_bits`=3'b001 while `pwr_down` is high. Any other code, and any write made while a sequence is active, has no effect.
- R3: The edge that accepts a start clears `pwr_down`. Then `conv_busy` stays low for exactly OSC_WAIT cycles and rises on the OSC_WAIT-th edge after the start edge.
- R4: The block converts each channel set in the sampled mask exactly once, in ascending index order. Each conversion takes CONV_CYCLES cycles, and the next one starts on the edge that completes the previous one.
- R5: On the edge that completes a conversion on channel c, during the n-th non-empty sequence since reset, the outputs become `res_data` = {n[15:0], 4'hC, c[3:0]} (24 bits), `res_chan` = c and `res_valid` = 1.
- R6: An accepted start clears `res_valid`. A cycle with `res_ready`=1 also clears it. A conversion that completes in the same cycle as `res_ready` leaves it set.
- R7: On the edge that publishes the last enabled channel's result, `conv_busy` falls and `pwr_down` rises. The two are never high together.
- R8: A start with an all-zero mask leaves `pwr_down` high, leaves `res_valid` unchanged and does not advance the sequence count n.
- R9: `res_data` and `res_chan` change only on conversion completion. Reads do not alter them.
- R10: The block samples the enable mask on the start edge. Later changes to `ch_enable` do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Mode write strobe |
| mode_bits | input | 3 | Mode code; 3'b001 = single pass |
| ch_enable | input | NUM_CH | Channel enable mask, sampled at start |
| res_valid | output | 1 | Ready flag: unread result present |
| res_ready | input | 1 | Reader has taken the result |
| res_data | output | DATA_W | Latest conversion result |
| res_chan | output | 4 | Channel tag of `res_data` |
| pwr_down | output | 1 | Block is powered down |
| conv_busy | output | 1 | A conversion is running |

## Verification
The assertions check on every cycle the following rules:
- busy and power-down are never high together;
- the warm-up lasts exactly OSC_WAIT cycles, measured by a counter in the checker;
- results change only while a conversion runs;
- the ready flag falls only on a read or a start;
- start, ignore and empty-mask decisions are taken from power-down.

Only the bench's scenarios can show:
- the ascending channel order;
- the exact data word and sequence count;
- the spacing of results at CONV_CYCLES;
- the precedence of completion over a read;
- that a mask changed in mid-sequence is ignored.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_WARM = 2'd1,
    SEQ_CONV = 2'd2
  } seq_state_t;

  localparam logic [2:0] MODE_SINGLE = 3'b001;
  localparam int PASS_W = 16;
  localparam int TAG_W  = 4;
endpackage

// File: rtl/conv_seq_chsel.sv
module conv_seq_chsel #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_CH-1:0] mask,
  output logic [IDX_W-1:0]  first_idx,
  output logic              any_set
);
  // lowest set bit wins: scan from the top so lower indices overwrite
  always_comb begin
    first_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i]) first_idx = IDX_W'(i);
    end
    any_set = |mask;
  end
endmodule

// File: rtl/conv_seq_core.sv
module conv_seq_core
  import conv_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 100,
  parameter int DATA_W      = 24,
  parameter int IDX_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  chan,
  input  logic [PASS_W-1:0] pass,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic [IDX_W-1:0]  done_chan
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [PASS_W-1:0] pass_q;

  assign done = active && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      done_chan <= '0;
      pass_q    <= '0;
    end else if (start) begin
      active    <= 1'b1;
      cnt       <= '0;
      done_chan <= chan;
      pass_q    <= pass;
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt + 1'b1;
    end
  end

  // test word standing in for the analog result
  assign data = DATA_W'({pass_q, 4'hC, TAG_W'(done_chan)});
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int IDX_W    = 2,
  parameter int OSC_WAIT = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [2:0]        mode_bits,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic              core_done,
  input  logic [IDX_W-1:0]  first_idx,
  input  logic              any_left,
  output logic [NUM_CH-1:0] pend_mask,
  output logic              core_start,
  output logic              seq_begin,
  output logic [PASS_W-1:0] pass_cnt,
  output seq_state_t        state
);
  localparam int WARM_W = $clog2(OSC_WAIT + 1);
  localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(OSC_WAIT - 1);

  logic [WARM_W-1:0] warm_cnt;
  logic              warm_end;
  logic [NUM_CH-1:0] pick_bit;

  assign seq_begin  = (state == SEQ_OFF) && mode_wr && (mode_bits == MODE_SINGLE)
                      && (|ch_enable);
  assign warm_end   = (state == SEQ_WARM) && (warm_cnt == WARM_LAST);
  assign core_start = warm_end || ((state == SEQ_CONV) && core_done && any_left);
  assign pick_bit   = NUM_CH'(1) << first_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_OFF;
      pend_mask <= '0;
      warm_cnt  <= '0;
      pass_cnt  <= '0;
    end else begin
      unique case (state)
        SEQ_OFF: begin
          if (seq_begin) begin
            state     <= SEQ_WARM;
            pend_mask <= ch_enable;
            warm_cnt  <= '0;
            pass_cnt  <= pass_cnt + 1'b1;
          end
        end
        SEQ_WARM: begin
          warm_cnt <= warm_cnt + 1'b1;
          if (warm_end) begin
            state     <= SEQ_CONV;
            pend_mask <= pend_mask & ~pick_bit;
          end
        end
        SEQ_CONV: begin
          if (core_done) begin
            if (any_left) pend_mask <= pend_mask & ~pick_bit;
            else          state     <= SEQ_OFF;
          end
        end
        default: state <= SEQ_OFF;
      endcase
    end
  end
endmodule

// File: rtl/conv_seq_outreg.sv
module conv_seq_outreg #(
  parameter int DATA_W = 24,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [IDX_W-1:0]  load_chan,
  input  logic              seq_begin,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [3:0]        res_chan
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_data  <= load_data;
      res_chan  <= 4'(load_chan);
    end else if (seq_begin || res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
  import conv_seq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 24,
  parameter int OSC_WAIT    = 2000,
  parameter int CONV_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [2:0]        mode_bits,
  input  logic [NUM_CH-1:0] ch_enable,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic [3:0]        res_chan,
  output logic              pwr_down,
  output logic              conv_busy
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  seq_state_t        state;
  logic [NUM_CH-1:0] pend_mask;
  logic [IDX_W-1:0]  first_idx, done_chan;
  logic              any_left, core_start, core_done, seq_begin;
  logic [PASS_W-1:0] pass_cnt;
  logic [DATA_W-1:0] core_data;

  conv_seq_chsel #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chsel (
    .mask(pend_mask), .first_idx(first_idx), .any_set(any_left)
  );

  conv_seq_ctrl #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .OSC_WAIT(OSC_WAIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_bits(mode_bits),
    .ch_enable(ch_enable), .core_done(core_done), .first_idx(first_idx),
    .any_left(any_left), .pend_mask(pend_mask), .core_start(core_start),
    .seq_begin(seq_begin), .pass_cnt(pass_cnt), .state(state)
  );

  conv_seq_core #(.CONV_CYCLES(CONV_CYCLES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(core_start), .chan(first_idx),
    .pass(pass_cnt), .done(core_done), .data(core_data), .done_chan(done_chan)
  );

  conv_seq_outreg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(core_done), .load_data(core_data),
    .load_chan(done_chan), .seq_begin(seq_begin), .res_ready(res_ready),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan)
  );

  assign pwr_down  = (state == SEQ_OFF);
  assign conv_busy = (state == SEQ_CONV);
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 24,
  parameter int OSC_WAIT = 2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wr,
  input logic [2:0]        mode_bits,
  input logic [NUM_CH-1:0] ch_enable,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic [3:0]        res_chan,
  input logic              pwr_down,
  input logic              conv_busy
);
  int  warm_seen;
  logic start_wr;
  assign start_wr = pwr_down && mode_wr && (mode_bits == 3'b001);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      warm_seen <= 0;
    else if (!pwr_down && !conv_busy) warm_seen <= warm_seen + 1;
    else if (pwr_down)               warm_seen <= 0;
  end

  assert_state_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_down && conv_busy));
  assert_last_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_busy) |-> pwr_down && res_valid);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && (|ch_enable) |=> !pwr_down && !conv_busy && !res_valid);
  assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down && !(start_wr && (|ch_enable)) |=> pwr_down);
  assert_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && (ch_enable == '0) && !res_ready |=> pwr_down && $stable(res_valid));
  assert_warm_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_busy) |-> warm_seen == OSC_WAIT);
  assert_warm_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && !conv_busy) |-> warm_seen < OSC_WAIT);
  assert_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_data) |-> $past(conv_busy) && res_valid);
  assert_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_chan < NUM_CH);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_busy) |-> $stable(res_data) && $stable(res_chan));
  assert_valid_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_valid) |-> $past(res_ready) || $past(start_wr));
endmodule

bind conv_seq_top conv_seq_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .OSC_WAIT(OSC_WAIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_bits(mode_bits),
  .ch_enable(ch_enable), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .res_chan(res_chan), .pwr_down(pwr_down),
  .conv_busy(conv_busy)
);

// File: tb/conv_seq_top_tb.sv
module conv_seq_top_tb;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 24;
  localparam int OSCW   = 12;
  localparam int CONVC  = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_wr = 1'b0;
  logic [2:0]        mode_bits = 3'b000;
  logic [NUM_CH-1:0] ch_enable = '0;
  logic              res_ready = 1'b0;
  logic              res_valid, pwr_down, conv_busy;
  logic [DATA_W-1:0] res_data;
  logic [3:0]        res_chan;

  int errors = 0;
  int checks = 0;
  int pass_n = 0;
  logic              exp_valid = 1'b0;
  logic [DATA_W-1:0] exp_data = '0;
  logic [3:0]        exp_chan = '0;
  bit                finished = 1'b0;

  always #4 clk = ~clk;

  conv_seq_top #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .OSC_WAIT(OSCW),
                 .CONV_CYCLES(CONVC)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_bits(mode_bits),
    .ch_enable(ch_enable), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_chan(res_chan), .pwr_down(pwr_down),
    .conv_busy(conv_busy)
  );

  function automatic logic [DATA_W-1:0] word_of(int n, int ch);
    return DATA_W'({16'(n), 4'hC, 4'(ch)});
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(string req);
    chk(req, 32'(res_valid), 32'(exp_valid));
    chk(req, 32'(res_data), 32'(exp_data));
    chk(req, 32'(res_chan), 32'(exp_chan));
  endtask

  // rmode: 0 no read, 1 read pulse mid conversion, 2 hold ready over a whole conversion
  task automatic run_seq(logic [NUM_CH-1:0] mask, int rmode, bit poke, bit scramble);
    mode_wr = 1'b1; mode_bits = 3'b001; ch_enable = mask;
    tick();
    mode_wr = 1'b0;
    if (scramble) ch_enable = NUM_CH'($urandom);  // R10: must be ignored
    if (mask == '0) begin
      chk("R8 pd", 32'(pwr_down), 1);
      chk_outputs("R8 outputs");
      return;
    end
    pass_n++;
    exp_valid = 1'b0;
    chk("R3 pd low", 32'(pwr_down), 0);
    chk("R3 busy low", 32'(conv_busy), 0);
    chk("R6 start clears", 32'(res_valid), 0);
    repeat (OSCW - 1) tick();
    chk("R3 still warming", 32'(conv_busy), 0);
    tick();
    chk("R3 busy rises", 32'(conv_busy), 1);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (!mask[ch]) continue;
      if (rmode == 2) res_ready = 1'b1;
      for (int c = 1; c <= CONVC; c++) begin
        if (c == 2 && rmode == 1) begin
          res_ready = 1'b1;
          tick();
          res_ready = 1'b0;
          exp_valid = 1'b0;
          chk_outputs("R9 read keeps data");
        end else if (c == 3 && poke) begin
          mode_wr = 1'b1; mode_bits = 3'b001;  // R2: ignored while active
          tick();
          mode_wr = 1'b0;
        end else begin
          tick();
        end
        if (c < CONVC && rmode != 2) chk_outputs("R4 no early update");
      end
      res_ready = 1'b0;
      exp_valid = 1'b1;
      exp_data  = word_of(pass_n, ch);
      exp_chan  = 4'(ch);
      chk_outputs("R5 R4 R6 result");
      if ((mask >> (ch + 1)) == '0) begin
        chk("R7 pd after last", 32'(pwr_down), 1);
        chk("R7 busy falls", 32'(conv_busy), 0);
      end else begin
        chk("R4 next runs", 32'(conv_busy), 1);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pd", 32'(pwr_down), 1);
    chk("R1 busy", 32'(conv_busy), 0);
    chk_outputs("R1 outputs");
    rst_n = 1'b1;
    tick();
    chk("R1 pd after release", 32'(pwr_down), 1);

    // R2: wrong codes in power-down are ignored
    for (int k = 0; k < 8; k++) begin
      if (k == 1) continue;
      mode_wr = 1'b1; mode_bits = 3'(k); ch_enable = '1;
      tick();
      mode_wr = 1'b0;
      tick();
      chk("R2 other code ignored", 32'(pwr_down), 1);
    end
    chk_outputs("R2 outputs unchanged");

    run_seq(4'b1111, 0, 1'b0, 1'b0);
    // R9: repeated reads keep data, flag clears
    repeat (5) tick();
    chk_outputs("R9 hold");
    res_ready = 1'b1; tick(); res_ready = 1'b0;
    exp_valid = 1'b0;
    chk_outputs("R6 read clears");
    repeat (3) tick();
    chk_outputs("R9 hold after read");

    run_seq(4'b0000, 0, 1'b0, 1'b0);            // R8 empty, flag low
    run_seq(4'b1000, 0, 1'b0, 1'b0);
    run_seq(4'b0000, 0, 1'b0, 1'b0);            // R8 empty, flag high stays
    run_seq(4'b0101, 2, 1'b1, 1'b1);            // R6 done beats read, R2, R10
    run_seq(4'b1010, 1, 1'b0, 1'b1);

    for (int r = 0; r < 12; r++) begin
      run_seq(NUM_CH'($urandom), int'($urandom % 3), 1'($urandom), 1'b1);
      repeat (int'($urandom % 4)) tick();
      chk("R7 idle between", 32'(pwr_down), 1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule